// File: doc/BRIEF.md
# Storage Host Controller Bring-Up Sequencer

This block is a small register-bus master that brings a multi-port storage host controller out of reset, with no processor involved. On a start pulse it records the controller's capability word and resets the controller, then polls until the reset finishes. After that it re-enables the controller's native command mode and restores the capability bits kept from the first read. Each implemented port is then quiesced, spun up and polled for a link. Its error and interrupt status is cleared, its interrupt mask is programmed, and its link state is recorded. The last step turns on the controller-wide interrupt enable.

The bus side carries one access at a time. The sequencer holds a request until the target acknowledges it, and read data returns with the acknowledge. Time-based waits come from a cycle counter whose length is derived from the clock frequency. The result is a one-cycle `done` pulse together with a bitmap of ports that reported a live link. If the reset never clears, `fail` is raised instead and stays high until the next start.

Top module: `hba_init_seq`

## Requirements
- R1: The capability word (offset 0x00) is read at the start of a run. The value later written back to offset 0x00 is that read with only bits 28 and 17 kept and bit 27 forced to one.
- R2: The sequencer reads host control (offset 0x04). It writes that value with bit 0 (reset) set only if bit 0 read as zero, and then re-reads host control until bit 0 is zero.
- R3: If bit 0 of host control is still set when the reset budget (RESET_US microseconds of clock) runs out, `fail` rises. No `done` pulse is produced, no further bus request is made, and `fail` holds until the next start.
- R4: After reset the sequencer writes host control = 0x8000_0000 and follows it directly with a read of host control. It then writes the saved capability value, then writes 0xF to the ports-implemented register (offset 0x0C), followed directly by a read of that register.
- R5: The port count is the low 5 bits of a second capability read plus one, clamped to MAX_PORTS. Port p's registers sit at 0x100 + p*0x80, and no port at or above the count is accessed.
- R6: If the port command register (port offset 0x18) has any of bits 15, 14, 4 or 0 set, the sequencer writes it back with those bits cleared. It then reads it once and waits at least STOP_US microseconds of clock before the next access.
- R7: The sequencer writes 0x2 (spin-up) to the port command register, then reads link status (port offset 0x28) until its low nibble equals 3, at most LINK_TRIES times.
- R8: Port error (offset 0x30) and port interrupt status (offset 0x10) are each read and written back with the value read, so write-one-to-clear bits end at zero. The value 1<<p is then written to host interrupt status (offset 0x08).
- R9: DEF_IRQ_MASK is written to port interrupt mask (offset 0x14). `link_map[p]` is set exactly when a final link-status read after that write shows a low nibble of 3, and bits for absent ports stay zero.
- R10: After the last port, host control is read, written back with bit 1 set, and read again. `done` is then high for exactly one cycle.
- R11: A start pulse while a run is in progress is ignored, and a start after a failure clears `fail`.
- R12: A bus request keeps its address, direction and write data unchanged until it is acknowledged, and at most one access is outstanding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse to begin a bring-up run when idle |
| bus_req | output | 1 | Register access request, held until acknowledged |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | ADDR_W | Byte address of the register |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | One-cycle acknowledge of the pending request |
| bus_rdata | input | 32 | Read data, valid with bus_ack |
| done | output | 1 | One-cycle pulse when the run completes |
| fail | output | 1 | Reset did not clear in time; held until next start |
| link_map | output | MAX_PORTS | Ports that reported a live link |

## Verification
The tight coincidence is the link poll's try limit and link detection landing on the same read. When a port first reports link-up on exactly its LINK_TRIES-th read, the loop must stop because of the detection and still set the bitmap bit. A port that comes up one read later must miss the poll yet be caught by the final status read. Directed runs set every port's link delay to LINK_TRIES and to LINK_TRIES+1, and random runs mix delays around the limit. The bench judges each case by the exact number of link-status reads each port received and by the resulting bitmap bit. A second overlap, a start pulse arriving mid-run, is judged by counting capability reads: a run makes exactly two.

// File: rtl/hba_seq_pkg.sv
package hba_seq_pkg;

    // host register offsets
    localparam int CAP_OFS   = 'h00;
    localparam int GCTL_OFS  = 'h04;
    localparam int GIRQ_OFS  = 'h08;
    localparam int PIMP_OFS  = 'h0C;
    // port block layout and offsets
    localparam int PORT_BASE   = 'h100;
    localparam int PORT_STRIDE = 'h80;
    localparam int PIRQ_OFS  = 'h10;
    localparam int PMASK_OFS = 'h14;
    localparam int PCMD_OFS  = 'h18;
    localparam int PLINK_OFS = 'h28;
    localparam int PERR_OFS  = 'h30;

    localparam logic [31:0] CAP_KEEP    = 32'h1002_0000;
    localparam logic [31:0] CAP_FORCE   = 32'h0800_0000;
    localparam logic [31:0] GCTL_RST    = 32'h0000_0001;
    localparam logic [31:0] GCTL_IRQEN  = 32'h0000_0002;
    localparam logic [31:0] GCTL_NATIVE = 32'h8000_0000;
    localparam logic [31:0] PIMP_ALL    = 32'h0000_000F;
    localparam logic [31:0] PCMD_ENG    = 32'h0000_C011;
    localparam logic [31:0] PCMD_SPIN   = 32'h0000_0002;
    localparam logic [3:0]  LINK_UP     = 4'h3;

    typedef enum logic [4:0] {
        ST_IDLE, ST_CAP_RD, ST_CTL_RD, ST_RST_WR, ST_RST_FL, ST_RST_POLL,
        ST_EN_WR, ST_EN_FL, ST_CAP_WR, ST_PI_WR, ST_PI_FL, ST_CAP2_RD,
        ST_PCMD_RD, ST_PSTOP_WR, ST_PSTOP_FL, ST_PSTOP_WAIT, ST_PSPIN_WR,
        ST_PLINK_POLL, ST_PERR_RD, ST_PERR_WR, ST_PIS_RD, ST_PIS_WR,
        ST_GIS_WR, ST_PMASK_WR, ST_PLINK_RD, ST_GIE_RD, ST_GIE_WR, ST_GIE_FL
    } seq_state_e;

endpackage

// File: rtl/hba_seq_timer.sv
module hba_seq_timer #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] preset,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = preset;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/hba_seq_busport.sv
module hba_seq_busport #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              go_we,
    input  logic [ADDR_W-1:0] go_addr,
    input  logic [DATA_W-1:0] go_wdata,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              xfer_done,
    output logic [DATA_W-1:0] xfer_rdata
);
    typedef struct packed {
        logic              req;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              done;
        logic [DATA_W-1:0] rdata;
    } bp_t;

    bp_t bp_d, bp_q;

    always_comb begin
        bp_d      = bp_q;
        bp_d.done = 1'b0;
        if (bp_q.req && bus_ack) begin
            bp_d.req   = 1'b0;
            bp_d.done  = 1'b1;
            bp_d.rdata = bus_rdata;
        end else if (go && !bp_q.req) begin
            bp_d.req   = 1'b1;
            bp_d.we    = go_we;
            bp_d.addr  = go_addr;
            bp_d.wdata = go_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bp_q <= '0;
        else        bp_q <= bp_d;
    end

    assign bus_req    = bp_q.req;
    assign bus_we     = bp_q.we;
    assign bus_addr   = bp_q.addr;
    assign bus_wdata  = bp_q.wdata;
    assign xfer_done  = bp_q.done;
    assign xfer_rdata = bp_q.rdata;

    // R12: request fields frozen until acknowledged
    p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        bp_q.req && !bus_ack |=> bp_q.req && $stable(bp_q.addr) &&
                                 $stable(bp_q.we) && $stable(bp_q.wdata));
    // R12: a new access is only launched with nothing outstanding
    p_one_out_r12: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> !bp_q.req && !bp_q.done);
endmodule

// File: rtl/hba_init_seq.sv
module hba_init_seq
    import hba_seq_pkg::*;
#(
    parameter int          ADDR_W       = 12,
    parameter int          MAX_PORTS    = 4,
    parameter int          LINK_TRIES   = 10,
    parameter int unsigned CLK_HZ       = 200_000_000,
    parameter int unsigned RESET_US     = 1_000_000,
    parameter int unsigned STOP_US      = 500_000,
    parameter logic [31:0] DEF_IRQ_MASK = 32'hFD80_00FF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    output logic                 bus_req,
    output logic                 bus_we,
    output logic [ADDR_W-1:0]    bus_addr,
    output logic [31:0]          bus_wdata,
    input  logic                 bus_ack,
    input  logic [31:0]          bus_rdata,
    output logic                 done,
    output logic                 fail,
    output logic [MAX_PORTS-1:0] link_map
);
    localparam int          DATA_W  = 32;
    localparam int          PW      = $clog2(MAX_PORTS + 1);
    localparam int          TW      = $clog2(LINK_TRIES + 1);
    localparam int unsigned CYC_US  = CLK_HZ / 1_000_000;
    localparam int unsigned RST_CYC = CYC_US * RESET_US;
    localparam int unsigned STP_CYC = CYC_US * STOP_US;
    localparam logic [ADDR_W-1:0] A_CAP  = ADDR_W'(CAP_OFS);
    localparam logic [ADDR_W-1:0] A_GCTL = ADDR_W'(GCTL_OFS);
    localparam logic [ADDR_W-1:0] A_GIRQ = ADDR_W'(GIRQ_OFS);
    localparam logic [ADDR_W-1:0] A_PIMP = ADDR_W'(PIMP_OFS);

    typedef struct packed {
        seq_state_e           state;
        logic                 issued;
        logic [31:0]          cap_save;
        logic [31:0]          tmp;
        logic [PW-1:0]        nports;
        logic [PW-1:0]        port;
        logic [TW-1:0]        tries;
        logic [MAX_PORTS-1:0] link_map;
        logic                 done;
        logic                 fail;
    } seq_t;

    seq_t s_d, s_q;

    logic              go, acc_en, acc_we;
    logic [ADDR_W-1:0] acc_addr, pbase;
    logic [31:0]       acc_wdata;
    logic              xfer_done;
    logic [31:0]       xfer_rdata;
    logic              tmr_load, tmr_expired;
    logic [31:0]       tmr_preset;
    logic [5:0]        cnt6;
    logic [MAX_PORTS-1:0] live_mask;

    always_comb begin
        for (int i = 0; i < MAX_PORTS; i++)
            live_mask[i] = (i < 32'(s_q.nports));
    end

    always_comb begin
        s_d        = s_q;
        s_d.done   = 1'b0;
        go         = 1'b0;
        tmr_load   = 1'b0;
        tmr_preset = RST_CYC;
        acc_en     = 1'b1;
        acc_we     = 1'b0;
        acc_addr   = A_GCTL;
        acc_wdata  = '0;
        pbase      = ADDR_W'(PORT_BASE) + ADDR_W'(s_q.port) * ADDR_W'(PORT_STRIDE);
        cnt6       = {1'b0, xfer_rdata[4:0]} + 6'd1;

        // access decode for the current step
        unique case (s_q.state)
            ST_IDLE, ST_PSTOP_WAIT: acc_en = 1'b0;
            ST_CAP_RD, ST_CAP2_RD:  acc_addr = A_CAP;
            ST_RST_WR:     begin acc_we = 1'b1; acc_wdata = s_q.tmp | GCTL_RST; end
            ST_EN_WR:      begin acc_we = 1'b1; acc_wdata = GCTL_NATIVE; end
            ST_CAP_WR:     begin acc_we = 1'b1; acc_addr = A_CAP; acc_wdata = s_q.cap_save; end
            ST_PI_WR:      begin acc_we = 1'b1; acc_addr = A_PIMP; acc_wdata = PIMP_ALL; end
            ST_PI_FL:      acc_addr = A_PIMP;
            ST_PCMD_RD, ST_PSTOP_FL: acc_addr = pbase + ADDR_W'(PCMD_OFS);
            ST_PSTOP_WR:   begin acc_we = 1'b1; acc_addr = pbase + ADDR_W'(PCMD_OFS);
                                 acc_wdata = s_q.tmp & ~PCMD_ENG; end
            ST_PSPIN_WR:   begin acc_we = 1'b1; acc_addr = pbase + ADDR_W'(PCMD_OFS);
                                 acc_wdata = PCMD_SPIN; end
            ST_PLINK_POLL, ST_PLINK_RD: acc_addr = pbase + ADDR_W'(PLINK_OFS);
            ST_PERR_RD:    acc_addr = pbase + ADDR_W'(PERR_OFS);
            ST_PERR_WR:    begin acc_we = 1'b1; acc_addr = pbase + ADDR_W'(PERR_OFS);
                                 acc_wdata = s_q.tmp; end
            ST_PIS_RD:     acc_addr = pbase + ADDR_W'(PIRQ_OFS);
            ST_PIS_WR:     begin acc_we = 1'b1; acc_addr = pbase + ADDR_W'(PIRQ_OFS);
                                 acc_wdata = s_q.tmp; end
            ST_GIS_WR:     begin acc_we = 1'b1; acc_addr = A_GIRQ;
                                 acc_wdata = DATA_W'(1) << s_q.port; end
            ST_PMASK_WR:   begin acc_we = 1'b1; acc_addr = pbase + ADDR_W'(PMASK_OFS);
                                 acc_wdata = DEF_IRQ_MASK; end
            ST_GIE_WR:     begin acc_we = 1'b1; acc_wdata = s_q.tmp | GCTL_IRQEN; end
            default: ;     // host-control reads use the defaults
        endcase

        if (acc_en && !s_q.issued) begin
            go         = 1'b1;
            s_d.issued = 1'b1;
        end
        if (xfer_done) s_d.issued = 1'b0;

        // step sequencing
        unique case (s_q.state)
            ST_IDLE: if (start) begin
                s_d.state    = ST_CAP_RD;
                s_d.fail     = 1'b0;
                s_d.link_map = '0;
            end
            ST_PSTOP_WAIT: if (tmr_expired) s_d.state = ST_PSPIN_WR;
            default: if (xfer_done) begin
                unique case (s_q.state)
                    ST_CAP_RD: begin
                        s_d.cap_save = (xfer_rdata & CAP_KEEP) | CAP_FORCE;
                        s_d.state    = ST_CTL_RD;
                    end
                    ST_CTL_RD: begin
                        s_d.tmp = xfer_rdata;
                        if (xfer_rdata[0]) begin
                            s_d.state = ST_RST_POLL;
                            tmr_load  = 1'b1;
                        end else begin
                            s_d.state = ST_RST_WR;
                        end
                    end
                    ST_RST_WR: s_d.state = ST_RST_FL;
                    ST_RST_FL: begin
                        s_d.state = ST_RST_POLL;
                        tmr_load  = 1'b1;
                    end
                    ST_RST_POLL: begin
                        if (!xfer_rdata[0]) begin
                            s_d.state = ST_EN_WR;
                        end else if (tmr_expired) begin
                            s_d.state = ST_IDLE;
                            s_d.fail  = 1'b1;
                        end
                    end
                    ST_EN_WR:  s_d.state = ST_EN_FL;
                    ST_EN_FL:  s_d.state = ST_CAP_WR;
                    ST_CAP_WR: s_d.state = ST_PI_WR;
                    ST_PI_WR:  s_d.state = ST_PI_FL;
                    ST_PI_FL:  s_d.state = ST_CAP2_RD;
                    ST_CAP2_RD: begin
                        s_d.nports = (32'(cnt6) > MAX_PORTS) ? PW'(MAX_PORTS) : PW'(cnt6);
                        s_d.port   = '0;
                        s_d.state  = ST_PCMD_RD;
                    end
                    ST_PCMD_RD: begin
                        s_d.tmp   = xfer_rdata;
                        s_d.state = ((xfer_rdata & PCMD_ENG) != '0) ? ST_PSTOP_WR : ST_PSPIN_WR;
                    end
                    ST_PSTOP_WR: s_d.state = ST_PSTOP_FL;
                    ST_PSTOP_FL: begin
                        s_d.state  = ST_PSTOP_WAIT;
                        tmr_load   = 1'b1;
                        tmr_preset = STP_CYC;
                    end
                    ST_PSPIN_WR: begin
                        s_d.state = ST_PLINK_POLL;
                        s_d.tries = '0;
                    end
                    ST_PLINK_POLL: begin
                        if (xfer_rdata[3:0] == LINK_UP || 32'(s_q.tries) == LINK_TRIES - 1)
                            s_d.state = ST_PERR_RD;
                        else
                            s_d.tries = s_q.tries + 1'b1;
                    end
                    ST_PERR_RD: begin s_d.tmp = xfer_rdata; s_d.state = ST_PERR_WR; end
                    ST_PERR_WR: s_d.state = ST_PIS_RD;
                    ST_PIS_RD:  begin s_d.tmp = xfer_rdata; s_d.state = ST_PIS_WR; end
                    ST_PIS_WR:  s_d.state = ST_GIS_WR;
                    ST_GIS_WR:  s_d.state = ST_PMASK_WR;
                    ST_PMASK_WR: s_d.state = ST_PLINK_RD;
                    ST_PLINK_RD: begin
                        if (xfer_rdata[3:0] == LINK_UP) s_d.link_map[s_q.port] = 1'b1;
                        if (s_q.port == s_q.nports - 1'b1) begin
                            s_d.state = ST_GIE_RD;
                        end else begin
                            s_d.port  = s_q.port + 1'b1;
                            s_d.state = ST_PCMD_RD;
                        end
                    end
                    ST_GIE_RD: begin s_d.tmp = xfer_rdata; s_d.state = ST_GIE_WR; end
                    ST_GIE_WR: s_d.state = ST_GIE_FL;
                    ST_GIE_FL: begin
                        s_d.state = ST_IDLE;
                        s_d.done  = 1'b1;
                    end
                    default: s_d.state = ST_IDLE;
                endcase
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{state: ST_IDLE, default: '0};
        else        s_q <= s_d;
    end

    hba_seq_busport #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
        .clk(clk), .rst_n(rst_n),
        .go(go), .go_we(acc_we), .go_addr(acc_addr), .go_wdata(acc_wdata),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .xfer_done(xfer_done), .xfer_rdata(xfer_rdata)
    );

    hba_seq_timer #(.CNT_W(32)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .preset(tmr_preset),
        .expired(tmr_expired)
    );

    assign done     = s_q.done;
    assign fail     = s_q.fail;
    assign link_map = s_q.link_map;

    // R10: completion is a single-cycle pulse
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R3: failure never coincides with completion
    p_fail_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> !done);
    // R3: a failed run leaves the bus quiet
    p_fail_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> !bus_req);
    // R6: no access while the engine-stop wait runs
    p_stop_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.state == ST_PSTOP_WAIT |-> !bus_req);
    // R9: no link bit for a port beyond the count
    p_link_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (link_map & ~live_mask) == '0);
    // R11: the first step is only re-entered from idle
    p_no_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.state != ST_IDLE && s_q.state != ST_CAP_RD |=> s_q.state != ST_CAP_RD);
endmodule

// File: tb/sim_hba_init_seq.sv
`timescale 1ns/1ps
module sim_hba_init_seq;
    localparam int          NP    = 4;
    localparam int          TRIES = 6;
    localparam int          STOPC = 40;
    localparam logic [31:0] DEFM  = 32'hFD80_00FF;
    localparam logic [31:0] ENG   = 32'h0000_C011;
    localparam logic [31:0] CAPWM = 32'h1802_0000;

    logic clk = 0, rst_n = 0, start = 0;
    logic bus_req, bus_we, bus_ack = 0;
    logic [11:0] bus_addr;
    logic [31:0] bus_wdata, bus_rdata = '0;
    logic done, fail;
    logic [NP-1:0] link_map;

    always #2.5 clk = ~clk;

    hba_init_seq #(.ADDR_W(12), .MAX_PORTS(NP), .LINK_TRIES(TRIES), .CLK_HZ(1_000_000),
                   .RESET_US(3000), .STOP_US(STOPC), .DEF_IRQ_MASK(DEFM)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
        .bus_rdata(bus_rdata), .done(done), .fail(fail), .link_map(link_map));

    int n_chk = 0, n_bad = 0;
    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // controller register model
    logic [31:0] m_cap, m_ctl, m_pi, m_gis, m_capw;
    logic [31:0] m_cmd[NP], m_cmd0[NP], m_err[NP], m_err0[NP], m_is[NP], m_is0[NP], m_mask[NP];
    int m_delay[NP], m_lreads[NP], m_stopwr[NP];
    bit m_spun[NP];
    int m_rst_cnt, m_rst_set, m_cap_reads, m_rst_wr, n_exp;
    bit m_en_seen;
    int en_fl, pi_fl, bad_stable, bad_gap, bad_stopval, bad_spin, bad_range, done_cyc;
    int cyc = 0, ack_cyc = 0, s_state = 0, s_lat = 0;
    bit stop_fl_pend = 0, cur_is_stopfl = 0, prev_we = 0;
    logic [11:0] prev_addr = '0, s_addr;
    logic [31:0] prev_wdata = '0, s_wdata;
    bit s_we;

    function automatic logic [31:0] host_rd(input logic [11:0] a);
        return '0;
    endfunction

    task automatic do_access();
        int p, o;
        logic [31:0] rd = '0;
        if (s_addr < 12'h100) begin
            if (!s_we) begin
                case (s_addr)
                    12'h000: begin rd = m_cap; m_cap_reads++; end
                    12'h004: begin
                        rd = m_ctl;
                        if (m_ctl[0]) begin
                            if (m_rst_cnt <= 1) m_ctl[0] = 1'b0; else m_rst_cnt--;
                        end
                    end
                    12'h008: rd = m_gis;
                    12'h00C: rd = m_pi;
                    default: rd = host_rd(s_addr);
                endcase
            end else begin
                case (s_addr)
                    12'h000: begin m_capw = s_wdata; m_cap = (m_cap & ~CAPWM) | (s_wdata & CAPWM); end
                    12'h004: begin
                        if (s_wdata[0] && !m_en_seen) m_rst_wr++;
                        if (s_wdata == 32'h8000_0000) m_en_seen = 1;
                        m_ctl = s_wdata;
                        if (s_wdata[0]) m_rst_cnt = m_rst_set;
                    end
                    12'h008: m_gis |= s_wdata;
                    12'h00C: m_pi = s_wdata;
                    default: ;
                endcase
            end
        end else begin
            p = (int'(s_addr) - 'h100) / 'h80;
            o = (int'(s_addr) - 'h100) % 'h80;
            if (p >= n_exp || p >= NP) bad_range++;
            else if (!s_we) begin
                case (o)
                    'h18: rd = m_cmd[p];
                    'h28: if (m_spun[p]) begin
                        m_lreads[p]++;
                        rd = (m_lreads[p] >= m_delay[p]) ? 32'h113 : 32'h1;
                    end
                    'h30: rd = m_err[p];
                    'h10: rd = m_is[p];
                    'h14: rd = m_mask[p];
                    default: ;
                endcase
            end else begin
                case (o)
                    'h18: begin
                        if (!s_wdata[1]) begin
                            m_stopwr[p]++;
                            if (s_wdata != (m_cmd0[p] & ~ENG)) bad_stopval++;
                        end else begin
                            if (s_wdata != 32'h2) bad_spin++;
                            m_spun[p] = 1; m_lreads[p] = 0;
                        end
                        m_cmd[p] = s_wdata;
                    end
                    'h30: m_err[p] &= ~s_wdata;
                    'h10: m_is[p]  &= ~s_wdata;
                    'h14: m_mask[p] = s_wdata;
                    default: ;
                endcase
            end
        end
        bus_rdata = rd;
    endtask

    // bus responder and monitors
    always @(negedge clk) begin
        cyc++;
        if (done) done_cyc++;
        if (s_state == 2) begin
            bus_ack = 0; s_state = 0;
        end else if (bus_req) begin
            if (s_state == 0) begin
                s_state = 1; s_lat = $urandom_range(0, 3);
                s_addr = bus_addr; s_we = bus_we; s_wdata = bus_wdata;
                if (stop_fl_pend) begin
                    if (cyc - ack_cyc < STOPC) bad_gap++;
                    stop_fl_pend = 0;
                end
                if (prev_we && prev_addr == 12'h004 && prev_wdata == 32'h8000_0000)
                    en_fl += (bus_addr == 12'h004 && !bus_we) ? 1 : 0;
                if (prev_we && prev_addr == 12'h00C)
                    pi_fl += (bus_addr == 12'h00C && !bus_we) ? 1 : 0;
                cur_is_stopfl = !bus_we && prev_we && prev_addr == bus_addr &&
                                bus_addr >= 12'h100 && bus_addr[6:0] == 7'h18 && !prev_wdata[1];
            end else if (bus_addr != s_addr || bus_we != s_we || bus_wdata != s_wdata) begin
                bad_stable++;
            end
            if (s_lat == 0) begin
                do_access();
                bus_ack = 1; s_state = 2;
                prev_we = s_we; prev_addr = s_addr; prev_wdata = s_wdata;
                if (cur_is_stopfl) begin stop_fl_pend = 1; ack_cyc = cyc; end
            end else s_lat--;
        end
    end

    task automatic setup(input int nf, input bit ctl_busy, input int rst_reads, input int dly_mode);
        m_cap = ($urandom & 32'hFFFF_FFE0) | 32'(nf);
        m_ctl = ctl_busy ? 32'h1 : 32'h0;
        m_rst_set = rst_reads; m_rst_cnt = rst_reads;
        m_pi = 0; m_gis = 0; m_capw = 0;
        m_cap_reads = 0; m_rst_wr = 0; m_en_seen = 0;
        en_fl = 0; pi_fl = 0; bad_stable = 0; bad_gap = 0; bad_stopval = 0;
        bad_spin = 0; bad_range = 0; done_cyc = 0;
        n_exp = (nf + 1 > NP) ? NP : nf + 1;
        for (int p = 0; p < NP; p++) begin
            m_cmd0[p] = $urandom & ~32'h2;
            if ($urandom_range(0, 1) == 0) m_cmd0[p] &= ~ENG;
            m_cmd[p] = m_cmd0[p];
            m_err0[p] = $urandom; m_err[p] = m_err0[p];
            m_is0[p] = $urandom;  m_is[p] = m_is0[p];
            m_mask[p] = 0; m_spun[p] = 0; m_lreads[p] = 0; m_stopwr[p] = 0;
            case (dly_mode)
                1: m_delay[p] = TRIES;
                2: m_delay[p] = TRIES + 1;
                3: m_delay[p] = TRIES + 3;
                4: m_delay[p] = 1;
                default: m_delay[p] = $urandom_range(1, TRIES + 3);
            endcase
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1;
        @(negedge clk) start = 0;
    endtask

    task automatic wait_end();
        int k = 0;
        while (done_cyc == 0 && !fail && k < 20000) begin @(negedge clk); k++; end
        repeat (3) @(negedge clk);
        chk(k < 20000, "R10 run end", 32'(k), 32'd20000);
    endtask

    task automatic run_ok(input int nf, input bit ctl_busy, input int dly_mode, input bit restart);
        logic [NP-1:0] exp_map;
        logic [31:0] exp_cap;
        setup(nf, ctl_busy, 3, dly_mode);
        exp_cap = (m_cap & 32'h1002_0000) | 32'h0800_0000;
        pulse_start();
        repeat (2) @(negedge clk);
        chk(fail == 0, "R11 fail cleared by start", 32'(fail), 0);
        if (restart) begin repeat (30) @(negedge clk); pulse_start(); end
        wait_end();
        chk(m_capw == exp_cap, "R1 capability write-back", m_capw, exp_cap);
        chk(m_rst_wr == (ctl_busy ? 0 : 1), "R2 reset write count", 32'(m_rst_wr), ctl_busy ? 0 : 1);
        chk(m_ctl[0] == 0, "R2 reset cleared", m_ctl, 0);
        chk(en_fl == 1 && pi_fl == 1, "R4 flush reads", 32'(en_fl * 16 + pi_fl), 32'h11);
        chk(m_pi == 32'hF, "R4 ports-implemented", m_pi, 32'hF);
        chk(bad_range == 0, "R5 port range", 32'(bad_range), 0);
        chk(m_cap_reads == 2, "R11 capability reads per run", 32'(m_cap_reads), 2);
        chk(bad_stopval == 0 && bad_gap == 0, "R6 stop value and wait",
            32'(bad_stopval * 256 + bad_gap), 0);
        chk(bad_spin == 0, "R7 spin-up value", 32'(bad_spin), 0);
        chk(m_gis == ((32'h1 << n_exp) - 1), "R8 host irq ack", m_gis, (32'h1 << n_exp) - 1);
        chk(bad_stable == 0, "R12 request stable", 32'(bad_stable), 0);
        chk(done_cyc == 1, "R10 done width", 32'(done_cyc), 1);
        chk(m_ctl == 32'h8000_0002, "R10 host control final", m_ctl, 32'h8000_0002);
        exp_map = '0;
        for (int p = 0; p < NP; p++) begin
            int exp_reads;
            if (p < n_exp) begin
                exp_reads = ((m_delay[p] < TRIES) ? m_delay[p] : TRIES) + 1;
                exp_map[p] = (m_delay[p] <= TRIES + 1);
                chk(m_stopwr[p] == (((m_cmd0[p] & ENG) != 0) ? 1 : 0), "R6 stop write count",
                    32'(m_stopwr[p]), ((m_cmd0[p] & ENG) != 0) ? 1 : 0);
                chk(m_lreads[p] == exp_reads, "R7 link status reads", 32'(m_lreads[p]), 32'(exp_reads));
                chk(m_err[p] == 0 && m_is[p] == 0, "R8 status cleared", m_err[p] | m_is[p], 0);
                chk(m_mask[p] == DEFM, "R9 irq mask", m_mask[p], DEFM);
            end else begin
                chk(m_err[p] == m_err0[p] && m_is[p] == m_is0[p] && m_mask[p] == 0,
                    "R5 absent port untouched", m_err[p], m_err0[p]);
            end
        end
        chk(link_map == exp_map, "R9 link bitmap", 32'(link_map), 32'(exp_map));
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog R10 actual=%0d expected=%0d", cyc, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(!done && !fail && link_map == 0 && !bus_req, "R10 reset state",
            {28'd0, done, fail, bus_req, 1'b0}, 0);
        // directed corners
        run_ok(0, 0, 0, 0);          // single port
        run_ok(7, 0, 0, 0);          // clamp to MAX_PORTS
        run_ok(3, 0, 1, 0);          // link on last allowed poll
        run_ok(3, 0, 2, 0);          // link one read after poll limit
        run_ok(3, 0, 3, 0);          // never links
        run_ok(3, 0, 4, 0);          // immediate link
        run_ok(2, 1, 0, 0);          // reset already in progress
        run_ok(3, 0, 0, 1);          // start while busy
        // reset timeout
        setup(3, 0, 1_000_000_000, 0);
        pulse_start();
        wait_end();
        chk(fail == 1, "R3 timeout fail", 32'(fail), 1);
        chk(done_cyc == 0 && !m_en_seen, "R3 no completion", 32'(done_cyc), 0);
        repeat (50) @(negedge clk);
        chk(fail == 1 && !bus_req, "R3 fail held bus idle", {30'd0, fail, bus_req}, 32'h2);
        // constrained random runs
        for (int i = 0; i < 10; i++)
            run_ok($urandom_range(0, 7), $urandom_range(0, 1), 0, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule